// File: doc/BRIEF.md
# Software Watchdog with Selectable Action

This block is a watchdog timer that software has to service at regular intervals. A down-counter advances on a prescaled tick. Software chooses how long the watchdog waits by writing a three-bit period code, which selects one of eight lengths spaced by powers of two. Software services the watchdog by writing a two-byte key into the block. If the counter runs out before a valid key arrives, the block takes one of two actions, chosen by a configuration bit:

- it raises a reset request for a fixed number of clocks, or
- it raises a highest-priority interrupt request that stays up until software services the watchdog.

An expired flag records that a timeout took place. With the enable low, the whole function is inactive. The tick source, the register bus and the interrupt controller sit outside the block. The block sees only a tick strobe, a write strobe with its data byte, and the three configuration inputs.

Top module: `wdog_guard`

## Requirements
- R1: Period code k (0 to 7) selects a timeout of 2^(BASE_EXP + EXP_STEP*k) ticks. With defaults this gives 2^9, 2^11, ..., 2^23. Without a valid service, the timeout fires on that many ticks after the last reload.
- R2: The counter moves only in cycles where tick_i is high. Cycles without a tick do not bring the timeout closer.
- R3: A write of 0x55 followed directly by a write of 0xAA reloads the counter to a full period and clears the pending key. A repeated 0x55 simply re-arms the key, so 0x55, 0x55, 0xAA also services the watchdog.
- R4: A write of any other value after 0x55 cancels the armed key. A lone 0xAA with no 0x55 before it has no effect. Neither case reloads the counter.
- R5: When act_irq_i is 0 (reset action), rst_req_o goes high on the clock after the timeout and stays high for exactly RST_HOLD (default 16) clocks.
- R6: When act_irq_i is 1 (interrupt action), nmi_o goes high on the clock after the timeout. It stays high until a service key completes, even if further timeouts or other writes occur.
- R7: expired_o goes high on the clock after any timeout. It is cleared by a completed service key or by disabling the block.
- R8: A change of per_sel_i reloads the counter, so the new period starts from its full count.
- R9: With en_i low, the counter is held at its reload value, no timeout occurs, and rst_req_o, nmi_o and expired_o are all low from the next clock on. The key sequence is also cancelled. After en_i rises, a full period is needed before a timeout.
- R10: After reset, rst_req_o, nmi_o and expired_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled tick strobe that advances the counter |
| en_i | input | 1 | Watchdog enable |
| act_irq_i | input | 1 | Timeout action: 0 reset request, 1 level-7 interrupt |
| per_sel_i | input | SEL_W | Period code |
| svc_wr_i | input | 1 | Service byte write strobe |
| svc_data_i | input | DATA_W | Service byte value |
| rst_req_o | output | 1 | Reset request |
| nmi_o | output | 1 | Level-7 interrupt request |
| expired_o | output | 1 | Timeout has occurred since the last service |

## Verification
The bench builds the block with BASE_EXP=5 and EXP_STEP=1, which gives periods of 32 to 4096 ticks. It keeps RST_HOLD at 16. These values let the bench exercise all eight period codes, counting each to the exact tick on which it fires, within a short run. The shortest period is still longer than the reset hold, so the full hold window can be measured between two timeouts. With tick_i driven every clock, each expiry lands on a cycle the bench can predict.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   typedef enum logic {
      WD_ACT_RESET = 1'b0,
      WD_ACT_IRQ   = 1'b1
   } wd_act_e;

   typedef enum logic {
      WD_KEY_IDLE  = 1'b0,
      WD_KEY_ARMED = 1'b1
   } wd_key_e;
endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq #(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] KEY_A = 8'h55,
   parameter logic [DATA_W-1:0] KEY_B = 8'hAA
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              done_o
);
   import wdog_pkg::*;

   wd_key_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      done_o  = 1'b0;
      if (!en_i) begin
         state_d = WD_KEY_IDLE;
      end else if (wr_i) begin
         if (data_i == KEY_A) begin
            state_d = WD_KEY_ARMED;
         end else if (state_q == WD_KEY_ARMED && data_i == KEY_B) begin
            state_d = WD_KEY_IDLE;
            done_o  = 1'b1;
         end else begin
            state_d = WD_KEY_IDLE;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= WD_KEY_IDLE;
      else         state_q <= state_d;
   end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned BASE_EXP = 9,
   parameter int unsigned EXP_STEP = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             svc_i,
   output logic             fire_o
);
   localparam int unsigned NUM_SEL = 1 << SEL_W;
   localparam int unsigned CNT_W   = BASE_EXP + EXP_STEP * (NUM_SEL - 1);

   logic [CNT_W-1:0] reload_tbl [NUM_SEL];

   for (genvar g = 0; g < NUM_SEL; g++) begin : g_tbl
      localparam int unsigned EXPO = BASE_EXP + EXP_STEP * g;
      assign reload_tbl[g] = {CNT_W{1'b1}} >> (CNT_W - EXPO);
   end

   logic [CNT_W-1:0] cnt_q;
   logic [SEL_W-1:0] sel_q;
   logic             reload;

   assign reload = !en_i || svc_i || (sel_i != sel_q);
   assign fire_o = en_i && tick_i && !reload && (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q <= '0;
         cnt_q <= reload_tbl[0];
      end else begin
         sel_q <= sel_i;
         if (reload) begin
            cnt_q <= reload_tbl[sel_i];
         end else if (tick_i) begin
            if (cnt_q == '0) cnt_q <= reload_tbl[sel_i];
            else             cnt_q <= cnt_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/wdog_action.sv
module wdog_action #(
   parameter int unsigned RST_HOLD = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic fire_i,
   input  logic svc_i,
   input  logic act_irq_i,
   output logic rst_req_o,
   output logic nmi_o,
   output logic expired_o
);
   import wdog_pkg::*;

   wd_act_e act;
   assign act = wd_act_e'(act_irq_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         nmi_o     <= 1'b0;
         expired_o <= 1'b0;
      end else if (!en_i) begin
         nmi_o     <= 1'b0;
         expired_o <= 1'b0;
      end else begin
         if (fire_i)     expired_o <= 1'b1;
         else if (svc_i) expired_o <= 1'b0;
         if (fire_i && act == WD_ACT_IRQ) nmi_o <= 1'b1;
         else if (svc_i)                  nmi_o <= 1'b0;
      end
   end

   if (RST_HOLD == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    rst_req_o <= 1'b0;
         else if (!en_i) rst_req_o <= 1'b0;
         else            rst_req_o <= fire_i && act == WD_ACT_RESET;
      end
   end else begin : g_hold
      localparam int unsigned HW = $clog2(RST_HOLD + 1);
      logic [HW-1:0] hold_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                            hold_q <= '0;
         else if (!en_i)                         hold_q <= '0;
         else if (fire_i && act == WD_ACT_RESET) hold_q <= HW'(RST_HOLD);
         else if (hold_q != '0)                  hold_q <= hold_q - 1'b1;
      end
      assign rst_req_o = (hold_q != '0);
   end
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned BASE_EXP = 9,
   parameter int unsigned EXP_STEP = 2,
   parameter int unsigned RST_HOLD = 16,
   parameter int unsigned DATA_W   = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              en_i,
   input  logic              act_irq_i,
   input  logic [SEL_W-1:0]  per_sel_i,
   input  logic              svc_wr_i,
   input  logic [DATA_W-1:0] svc_data_i,
   output logic              rst_req_o,
   output logic              nmi_o,
   output logic              expired_o
);
   localparam int unsigned MAX_EXP = BASE_EXP + EXP_STEP * ((1 << SEL_W) - 1);

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("wdog_guard: SEL_W must be 1..4");
   end
   if (BASE_EXP < 1 || MAX_EXP > 31) begin : g_bad_exp
      $error("wdog_guard: period exponents must lie in 1..31");
   end
   if (RST_HOLD < 1 || (1 << BASE_EXP) <= RST_HOLD) begin : g_bad_hold
      $error("wdog_guard: RST_HOLD must be nonzero and below the shortest period");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("wdog_guard: service keys are bytes, DATA_W must be 8");
   end

   logic svc_ok;
   logic fire;

   wdog_key_seq #(.DATA_W(DATA_W)) u_key (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .wr_i  (svc_wr_i),
      .data_i(svc_data_i),
      .done_o(svc_ok)
   );

   wdog_count #(.SEL_W(SEL_W), .BASE_EXP(BASE_EXP), .EXP_STEP(EXP_STEP)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .tick_i(tick_i),
      .sel_i (per_sel_i),
      .svc_i (svc_ok),
      .fire_o(fire)
   );

   wdog_action #(.RST_HOLD(RST_HOLD)) u_act (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .fire_i   (fire),
      .svc_i    (svc_ok),
      .act_irq_i(act_irq_i),
      .rst_req_o(rst_req_o),
      .nmi_o    (nmi_o),
      .expired_o(expired_o)
   );
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
   parameter int unsigned RST_HOLD = 16
) (
   input logic clk_i,
   input logic rst_ni,
   input logic en_i,
   input logic fire,
   input logic svc_ok,
   input logic rst_req_o,
   input logic nmi_o,
   input logic expired_o
);
   localparam int unsigned HW = $clog2(RST_HOLD + 2);
   logic [HW-1:0] hi_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          hi_cnt <= '0;
      else if (!rst_req_o)                  hi_cnt <= '0;
      else if (hi_cnt != HW'(RST_HOLD + 1)) hi_cnt <= hi_cnt + 1'b1;
   end

   assert_quiet_when_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!rst_req_o && !nmi_o && !expired_o));

   assert_nmi_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (nmi_o && en_i && !svc_ok) |=> nmi_o);

   assert_nmi_after_fire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(nmi_o) |-> $past(fire));

   assert_rst_len_max_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |-> (hi_cnt < HW'(RST_HOLD)));

   assert_rst_len_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(rst_req_o) && $past(en_i)) |-> (hi_cnt == HW'(RST_HOLD)));

   assert_flag_on_fire_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire |=> expired_o);

   assert_flag_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      svc_ok |=> !expired_o);
endmodule

bind wdog_guard wdog_guard_chk #(.RST_HOLD(RST_HOLD)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .en_i     (en_i),
   .fire     (fire),
   .svc_ok   (svc_ok),
   .rst_req_o(rst_req_o),
   .nmi_o    (nmi_o),
   .expired_o(expired_o)
);

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb;
   localparam int unsigned BASE = 5;
   localparam int unsigned STEP = 1;
   localparam int unsigned HOLD = 16;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       tick_i = 1'b1;
   logic       en_i = 1'b1;
   logic       act_irq_i = 1'b1;
   logic [2:0] per_sel_i = 3'd0;
   logic       svc_wr_i = 1'b0;
   logic [7:0] svc_data_i = 8'h00;
   logic       rst_req_o, nmi_o, expired_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk_i = ~clk_i;

   wdog_guard #(.SEL_W(3), .BASE_EXP(BASE), .EXP_STEP(STEP), .RST_HOLD(HOLD), .DATA_W(8)) u_dut (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .en_i(en_i),
      .act_irq_i(act_irq_i), .per_sel_i(per_sel_i), .svc_wr_i(svc_wr_i),
      .svc_data_i(svc_data_i), .rst_req_o(rst_req_o), .nmi_o(nmi_o), .expired_o(expired_o)
   );

   function automatic int period(int k);
      return 1 << (BASE + STEP * k);
   endfunction

   task automatic chk(int act, int exp, string req, string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr_byte(logic [7:0] d);
      @(negedge clk_i);
      svc_wr_i = 1'b1;
      svc_data_i = d;
   endtask

   task automatic idle();
      @(negedge clk_i);
      svc_wr_i = 1'b0;
   endtask

   // full service: returns at the negedge right after the reload edge
   task automatic svc();
      wr_byte(8'h55);
      wr_byte(8'hAA);
      idle();
   endtask

   // expects the timeout flag to stay low through tick P-1 and rise at tick P
   task automatic expect_expire(int p, int already, string req);
      repeat (p - 1 - already) @(negedge clk_i);
      chk(expired_o, 0, req, "flag one tick before timeout");
      @(negedge clk_i);
      chk(expired_o, 1, req, "flag at timeout");
   endtask

   task automatic t_reset();
      chk(rst_req_o, 0, "R10", "rst_req in reset");
      chk(nmi_o, 0, "R10", "nmi in reset");
      chk(expired_o, 0, "R10", "expired in reset");
      @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      chk(rst_req_o | nmi_o | expired_o, 0, "R10", "outputs after reset");
   endtask

   task automatic t_periods();
      act_irq_i = 1'b1;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk_i);
         per_sel_i = 3'(k);
         svc();
         expect_expire(period(k), 0, "R1");
      end
      per_sel_i = 3'd0;
      svc();
   endtask

   task automatic t_tick_gate();
      svc();
      tick_i = 1'b0;
      repeat (100) @(negedge clk_i);
      chk(expired_o, 0, "R2", "no timeout without ticks");
      tick_i = 1'b1;
      expect_expire(period(0), 0, "R2");
   endtask

   task automatic t_key_good();
      svc();
      repeat (20) @(negedge clk_i);
      svc();
      expect_expire(period(0), 0, "R3");
      wr_byte(8'h55);
      wr_byte(8'h55);
      wr_byte(8'hAA);
      idle();
      expect_expire(period(0), 0, "R3");
   endtask

   task automatic t_key_bad();
      svc();
      wr_byte(8'h55);
      wr_byte(8'h13);
      wr_byte(8'hAA);
      idle();
      expect_expire(period(0), 4, "R4");
      svc();
      wr_byte(8'hAA);
      idle();
      expect_expire(period(0), 2, "R4");
   endtask

   task automatic t_reset_action();
      int n = 0;
      act_irq_i = 1'b0;
      svc();
      expect_expire(period(0), 0, "R5");
      chk(nmi_o, 0, "R5", "nmi in reset action");
      while (rst_req_o && n < 40) begin
         n++;
         @(negedge clk_i);
      end
      chk(n, HOLD, "R5", "reset request width");
      en_i = 1'b0;
      @(negedge clk_i);
      en_i = 1'b1;
      act_irq_i = 1'b1;
   endtask

   task automatic t_irq_action();
      act_irq_i = 1'b1;
      svc();
      expect_expire(period(0), 0, "R6");
      chk(nmi_o, 1, "R6", "nmi after timeout");
      chk(rst_req_o, 0, "R6", "no reset in irq action");
      wr_byte(8'h55);
      wr_byte(8'h13);
      idle();
      repeat (40) @(negedge clk_i);
      chk(nmi_o, 1, "R6", "nmi held through bad key and re-timeout");
      svc();
      chk(nmi_o, 0, "R6", "nmi cleared by service");
      chk(expired_o, 0, "R7", "flag cleared by service");
   endtask

   task automatic t_sel_change();
      per_sel_i = 3'd0;
      svc();
      repeat (20) @(negedge clk_i);
      per_sel_i = 3'd1;
      @(negedge clk_i);
      expect_expire(period(1), 0, "R8");
      per_sel_i = 3'd0;
      svc();
   endtask

   task automatic t_disable();
      svc();
      expect_expire(period(0), 0, "R9");
      en_i = 1'b0;
      @(negedge clk_i);
      chk(nmi_o | expired_o | rst_req_o, 0, "R9", "outputs cleared on disable");
      chk(expired_o, 0, "R7", "flag cleared by disable");
      wr_byte(8'h55);
      wr_byte(8'hAA);
      idle();
      repeat (200) @(negedge clk_i);
      chk(nmi_o | expired_o | rst_req_o, 0, "R9", "outputs quiet while disabled");
      en_i = 1'b1;
      expect_expire(period(0), 0, "R9");
   endtask

   initial begin
      t_reset();
      t_periods();
      t_tick_gate();
      t_key_good();
      t_key_bad();
      t_reset_action();
      t_irq_action();
      t_sel_change();
      t_disable();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk_i);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule